// File: doc/BRIEF.md
# Rising-Edge Two-Cycle Pulse Generator

This block watches a single slowly changing input level and turns each low-to-high change of it into an output pulse exactly two clock periods wide. The input is captured only on the falling clock edge, so a level that settles during the high half of the clock is taken in half a period later. The rest of the machine runs on the rising edge. A high-to-low change of the input produces nothing. An input that stays high after its pulse keeps the output low until the input has dropped and risen again.

Inside, a falling-edge capture flop feeds an edge detector. The edge detector holds the previously captured level. A four-state Moore machine (idle-low, first pulse period, second pulse period, waiting-while-high) drives the output from its state alone. The input is assumed to change far more slowly than the clock: each level lasts many falling edges.

Top module: `rise_pulse2_gen`

## Requirements
- R1: The input x_i is captured only on the falling edge of clk_i. A change made just after a falling edge has no effect on z_o until the next falling edge has captured it.
- R2: When the captured level goes from 0 to 1, z_o becomes 1 at the first rising edge after the falling edge that captured the 1. The bench checks this one half period after that falling edge.
- R3: Each pulse on z_o lasts exactly two clock periods and then returns to 0.
- R4: While x_i stays high after a pulse, z_o stays 0. No further pulse occurs until x_i has been captured low and then high again.
- R5: A 1-to-0 change of x_i produces no pulse. z_o stays 0.
- R6: rst_ni is active-low and asynchronous. While it is 0, z_o is 0, the machine is idle, and both the captured level and the remembered previous level are 0. If x_i is high when reset is released, this counts as a 0-to-1 change and yields one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock. The input is captured on the falling edge and the state changes on the rising edge. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Slowly changing level to watch |
| z_o | output | 1 | Pulse output, high for two periods per rising change of x_i |

## Verification
The hardest case to reach is a level change that lands between a falling edge and the next rising edge. A design that sampled on the rising edge would react one period early, and a correct one must not. The stimulus covers it by moving some input changes to just after the falling edge, and the reference model captures the level at the falling edge. Long high holds and a reset released with the input already high reach the waiting state and the reset-as-edge case.

// File: rtl/rise_pulse2_pkg.sv
package rise_pulse2_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE_LO = 2'd0,
    ST_PULSE_A = 2'd1,
    ST_PULSE_B = 2'd2,
    ST_WAIT_HI = 2'd3
  } pg_state_e;

  function automatic logic pg_out(input pg_state_e s);
    return (s == ST_PULSE_A) || (s == ST_PULSE_B);
  endfunction
endpackage

// File: rtl/rise_pulse2_sampler.sv
module rise_pulse2_sampler #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic x_s_o
);
  // falling-edge capture of the slow input
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_s_o <= RST_VAL;
    else         x_s_o <= x_i;
  end
endmodule

// File: rtl/rise_pulse2_edge.sv
module rise_pulse2_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_s_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= x_s_i;
  end

  assign rise_o = x_s_i & ~prev_q;
endmodule

// File: rtl/rise_pulse2_fsm.sv
module rise_pulse2_fsm
  import rise_pulse2_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_s_i,
  input  logic rise_i,
  output logic z_o
);
  pg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE_LO: if (rise_i) state_d = ST_PULSE_A;
      ST_PULSE_A: state_d = ST_PULSE_B;
      ST_PULSE_B: state_d = x_s_i ? ST_WAIT_HI : ST_IDLE_LO;
      ST_WAIT_HI: if (!x_s_i) state_d = ST_IDLE_LO;
      default:    state_d = ST_IDLE_LO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE_LO;
    else         state_q <= state_d;
  end

  assign z_o = pg_out(state_q);

  // R2
  rise_starts_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(z_o) |-> $past(rise_i));
  // R3
  pulse_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(z_o) |=> z_o);
  // R3
  pulse_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_o && $past(z_o)) |=> !z_o);
  // R4
  no_spurious_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!z_o && !rise_i) |=> !z_o);
  // R5
  fall_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!x_s_i && !z_o) |=> !z_o);
endmodule

// File: rtl/rise_pulse2_gen.sv
module rise_pulse2_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_o
);
  logic x_s, rise;

  rise_pulse2_sampler #(.RST_VAL(1'b0)) u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (x_i),
    .x_s_o (x_s)
  );

  rise_pulse2_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_s_i (x_s),
    .rise_o(rise)
  );

  rise_pulse2_fsm u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_s_i (x_s),
    .rise_i(rise),
    .z_o   (z_o)
  );

  // R6
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !z_o);
endmodule

// File: tb/tb_rise_pulse2_gen.sv
`timescale 1ns/1ps
module tb_rise_pulse2_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic z;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;

  // bench reference model
  logic xs_m, prev_m;
  int   ph_m;
  int   run_len;
  int   exp_pulses, seen_pulses;

  rise_pulse2_gen dut (.clk_i(clk), .rst_ni(rst_n), .x_i(x), .z_o(z));

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic int model_ph(input int ph, input logic rise);
    if (ph == 0) return rise ? 1 : 0;
    if (ph == 1) return 2;
    return 0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic run_cycle(input logic xv, input bit late);
    logic rise;
    string req;
    @(posedge clk);
    #2;
    if (!late) x = xv;
    rise   = xs_m & ~prev_m;
    prev_m = xs_m;
    ph_m   = model_ph(ph_m, rise);
    if (ph_m == 1) exp_pulses++;
    if (ph_m != 0)            req = (ph_m == 1) ? "R2" : "R3";
    else if (late)            req = "R1";
    else if (xs_m)            req = "R4";
    else                      req = "R5";
    chk(req, z, ph_m != 0);
    if (z === 1'b1) run_len++;
    else if (run_len != 0) begin
      seen_pulses++;
      n_tests++;
      if (run_len != 2) begin
        n_fail++;
        $display("FAIL R3 pulse width: actual=%0d expected=2", run_len);
      end
      run_len = 0;
    end
    @(negedge clk);
    xs_m = x;
    if (late) begin
      #2;
      x = xv;
    end
  endtask

  task automatic hold(input logic xv, input int n, input bit late_first);
    for (int i = 0; i < n; i++) run_cycle(xv, late_first && (i == 0));
  endtask

  task automatic do_reset(input logic xv);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    x = xv;
    #1;
    chk("R6", z, 1'b0);
    xs_m = 1'b0; prev_m = 1'b0; ph_m = 0;
    if (run_len != 0) seen_pulses++;
    run_len = 0;
    @(posedge clk);
    #2;
    chk("R6", z, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    xs_m = x;
  endtask

  initial begin
    int seed_dummy;
    logic lvl;
    seed_dummy = $urandom(32'd48611);
    xs_m = 1'b0; prev_m = 1'b0; ph_m = 0;
    run_len = 0; exp_pulses = 0; seen_pulses = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R6", z, 1'b0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    xs_m = x;

    // directed: plain rise, long high hold, fall
    hold(1'b0, 8, 1'b0);
    hold(1'b1, 100, 1'b0);   // R4 long hold
    hold(1'b0, 10, 1'b0);    // R5
    // directed: late change just after falling edge (R1)
    hold(1'b1, 9, 1'b1);
    hold(1'b0, 9, 1'b1);
    // directed: reset released with input high (R6)
    do_reset(1'b1);
    hold(1'b1, 10, 1'b0);
    hold(1'b0, 10, 1'b0);
    // reset in the middle of a pulse
    hold(1'b1, 1, 1'b0);
    hold(1'b1, 1, 1'b0);
    do_reset(1'b0);
    hold(1'b0, 10, 1'b0);

    // random slow toggling
    lvl = 1'b0;
    for (int s = 0; s < 80; s++) begin
      lvl = ~lvl;
      hold(lvl, 8 + int'($urandom_range(0, 16)), ($urandom_range(0, 3) == 0));
    end
    hold(1'b0, 10, 1'b0);

    n_tests++;
    if (seen_pulses != exp_pulses) begin
      n_fail++;
      $display("FAIL R2 pulse count: actual=%0d expected=%0d", seen_pulses, exp_pulses);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule